// File: doc/BRIEF.md
# Partitioned Shared-RAM Ingress Queue Buffer

This block sits on the receiving side of a multi-port packet link. It keeps one FIFO for each logical port, and all of those FIFOs live in a single RAM. The RAM has one write port and one read port, and every logical queue shares them. Software-free static configuration inputs give each port a base address and a region size. Inside its own region, each port keeps a write offset, a read offset and an entry counter. The offsets wrap back to the start of the region.

For each port the block reports one ready bit that tells the upstream sender whether it may send one more burst. The bit is computed with extra headroom. It stays high only while the free space in the region is at least one burst plus a latency margin. This margin is sized to cover the data that is already on its way when the sender sees the bit drop. A write that arrives when the region is truly full is discarded and sets a sticky per-port overrun flag. A read from an empty queue produces no valid beat. A per-port configuration error flag marks regions that are too small for the margin or that do not fit in the RAM.

Top module: `mq_shared_buf`

## Requirements
- R1: While reset is high (synchronous, active-high), every port level and overrun flag clears to 0 and `rd_valid` clears to 0. After reset, every port's offsets start at its region base.
- R2: Each port returns its entries in the order they were written. An accepted read on cycle N produces `rd_valid`=1 and the entry on `rd_data` after the clock edge that ends cycle N.
- R3: A port's entries are stored at region base plus an offset. The offset steps from size-1 back to 0, so repeated traffic around the region never disturbs another port's data.
- R4: `port_ready[p]` is 1 exactly when (size - level) >= (`cfg_burst` + `cfg_margin`).
- R5: Port levels, and the ready bits derived from them, change at the clock edge that accepts a write or read. An accepted write and an accepted read on the same port in the same cycle leave that port's level unchanged.
- R6: A write to a port whose level equals its size is dropped and sets `port_ovr[p]`. The flag stays at 1 until reset.
- R7: A read request to a port whose level is 0 is ignored. `rd_valid` is 0 after that edge and no level changes.
- R8: `cfg_err[p]` is 1 when size is 0, when size < 2*`cfg_margin`, or when base + size > 2^AW.
- R9: A write to one port and a read from a different port in the same cycle are both accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_base | input | NPORT*AW | Region base per port, port p in bits [p*AW +: AW] |
| cfg_size | input | NPORT*(AW+1) | Region size per port, port p in bits [p*(AW+1) +: AW+1] |
| cfg_burst | input | AW+1 | Entries granted per ready indication |
| cfg_margin | input | AW+1 | Latency headroom in entries |
| wr_en | input | 1 | Write request |
| wr_port | input | log2(NPORT) | Port addressed by the write |
| wr_data | input | DW | Write data |
| rd_en | input | 1 | Read request |
| rd_port | input | log2(NPORT) | Port addressed by the read |
| rd_valid | output | 1 | Read data valid, one cycle after an accepted read |
| rd_data | output | DW | Read data |
| port_ready | output | NPORT | Per-port ready-for-burst status |
| port_level | output | NPORT*(AW+1) | Per-port entry count |
| port_ovr | output | NPORT | Sticky per-port overrun flag |
| cfg_err | output | NPORT | Per-port configuration error |

## Verification
Levels, ready bits and overrun flags come from registers that update at the edge that accepts a request, so they are due one edge after the request is driven. `rd_valid` and `rd_data` come from the RAM's output register, so they are also due one edge after an accepted read. The configuration error flags are combinational and are due as soon as the configuration changes. The bench drives each request at a falling edge and steps a behavioural queue model to match. It then waits for the next rising edge and compares every output at the following falling edge, so each comparison sees exactly one edge's worth of change.

// File: rtl/mq_pkg.sv
package mq_pkg;

    // Request pair presented to one port controller.
    typedef struct packed {
        logic push;
        logic pop;
    } port_req_t;

    // Result of a request: accepted or not.
    typedef enum logic [1:0] {
        OP_IDLE  = 2'b00,
        OP_PUSH  = 2'b10,
        OP_POP   = 2'b01,
        OP_BOTH  = 2'b11
    } op_kind_t;

    // Offset step inside a circular region of the given size.
    function automatic int unsigned ring_next(int unsigned off, int unsigned size);
        return (off + 1 >= size) ? 0 : off + 1;
    endfunction

    // Region is unusable: empty, too small for the headroom, or past the RAM end.
    function automatic logic region_bad(int unsigned base, int unsigned size,
                                        int unsigned margin, int unsigned depth);
        return (size == 0) || (size < 2 * margin) || (base + size > depth);
    endfunction

endpackage

// File: rtl/mq_ram.sv
module mq_ram #(
    parameter int AW = 6,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (re) rdata <= mem[raddr];
    end
endmodule

// File: rtl/mq_cfg_check.sv
module mq_cfg_check #(
    parameter int AW = 6,
    parameter int CW = AW + 1
) (
    input  logic [AW-1:0] base,
    input  logic [CW-1:0] size,
    input  logic [CW-1:0] margin,
    output logic          err
);
    import mq_pkg::*;
    localparam int DEPTH = 1 << AW;

    always_comb err = region_bad(32'(base), 32'(size), 32'(margin), DEPTH);
endmodule

// File: rtl/mq_port_ctrl.sv
module mq_port_ctrl
    import mq_pkg::*;
#(
    parameter int AW = 6,
    parameter int CW = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] cfg_base,
    input  logic [CW-1:0] cfg_size,
    input  logic [CW:0]   need,
    input  port_req_t     req,
    output logic          push_ok,
    output logic          pop_ok,
    output logic [AW-1:0] wr_addr,
    output logic [AW-1:0] rd_addr,
    output logic [CW-1:0] level,
    output logic          ready,
    output logic          ovr
);
    logic [AW-1:0] wr_off, rd_off;
    logic [CW-1:0] lvl_q;
    logic          ovr_q;
    logic [CW-1:0] free_sp;
    op_kind_t      op;

    always_comb begin
        push_ok = req.push && (lvl_q < cfg_size);
        pop_ok  = req.pop && (lvl_q != '0);
        op      = op_kind_t'({push_ok, pop_ok});
        free_sp = cfg_size - lvl_q;
        ready   = ({1'b0, free_sp} >= need);
        wr_addr = cfg_base + wr_off;
        rd_addr = cfg_base + rd_off;
        level   = lvl_q;
        ovr     = ovr_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_off <= '0;
            rd_off <= '0;
            lvl_q  <= '0;
            ovr_q  <= 1'b0;
        end else begin
            if (push_ok) wr_off <= AW'(ring_next(32'(wr_off), 32'(cfg_size)));
            if (pop_ok)  rd_off <= AW'(ring_next(32'(rd_off), 32'(cfg_size)));
            if (req.push && !push_ok) ovr_q <= 1'b1;
            case (op)
                OP_PUSH: lvl_q <= lvl_q + 1'b1;
                OP_POP:  lvl_q <= lvl_q - 1'b1;
                default: lvl_q <= lvl_q;
            endcase
        end
    end

    // R6
    lvl_bound_chk: assert property (@(posedge clk) disable iff (rst)
        lvl_q <= cfg_size);

    // R6
    ovr_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        ovr_q |=> ovr_q);

    // R5
    both_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (push_ok && pop_ok) |=> $stable(lvl_q));

    // R4
    full_not_ready_chk: assert property (@(posedge clk) disable iff (rst)
        (lvl_q == cfg_size && need != '0) |-> !ready);
endmodule

// File: rtl/mq_shared_buf.sv
module mq_shared_buf
    import mq_pkg::*;
#(
    parameter int NPORT = 4,
    parameter int AW    = 6,
    parameter int DW    = 16,
    localparam int PW   = $clog2(NPORT),
    localparam int CW   = AW + 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NPORT*AW-1:0] cfg_base,
    input  logic [NPORT*CW-1:0] cfg_size,
    input  logic [CW-1:0]      cfg_burst,
    input  logic [CW-1:0]      cfg_margin,
    input  logic               wr_en,
    input  logic [PW-1:0]      wr_port,
    input  logic [DW-1:0]      wr_data,
    input  logic               rd_en,
    input  logic [PW-1:0]      rd_port,
    output logic               rd_valid,
    output logic [DW-1:0]      rd_data,
    output logic [NPORT-1:0]   port_ready,
    output logic [NPORT*CW-1:0] port_level,
    output logic [NPORT-1:0]   port_ovr,
    output logic [NPORT-1:0]   cfg_err
);
    logic [CW:0]     need;
    logic [NPORT-1:0] push_v, pop_v;
    logic [AW-1:0]   wa_a [NPORT];
    logic [AW-1:0]   ra_a [NPORT];
    logic [CW-1:0]   lvl_a [NPORT];
    logic            push_any, pop_any;
    logic [AW-1:0]   waddr, raddr;
    logic            rv_q;

    always_comb need = {1'b0, cfg_burst} + {1'b0, cfg_margin};

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        port_req_t req;
        always_comb begin
            req.push = wr_en && (wr_port == PW'(p));
            req.pop  = rd_en && (rd_port == PW'(p));
        end

        mq_port_ctrl #(.AW(AW), .CW(CW)) u_ctrl (
            .clk      (clk),
            .rst      (rst),
            .cfg_base (cfg_base[p*AW +: AW]),
            .cfg_size (cfg_size[p*CW +: CW]),
            .need     (need),
            .req      (req),
            .push_ok  (push_v[p]),
            .pop_ok   (pop_v[p]),
            .wr_addr  (wa_a[p]),
            .rd_addr  (ra_a[p]),
            .level    (lvl_a[p]),
            .ready    (port_ready[p]),
            .ovr      (port_ovr[p])
        );

        mq_cfg_check #(.AW(AW), .CW(CW)) u_chk (
            .base   (cfg_base[p*AW +: AW]),
            .size   (cfg_size[p*CW +: CW]),
            .margin (cfg_margin),
            .err    (cfg_err[p])
        );

        always_comb port_level[p*CW +: CW] = lvl_a[p];
    end

    always_comb begin
        push_any = |push_v;
        pop_any  = |pop_v;
        waddr    = wa_a[wr_port];
        raddr    = ra_a[rd_port];
    end

    mq_ram #(.AW(AW), .DW(DW)) u_ram (
        .clk   (clk),
        .we    (push_any),
        .waddr (waddr),
        .wdata (wr_data),
        .re    (pop_any),
        .raddr (raddr),
        .rdata (rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst) rv_q <= 1'b0;
        else     rv_q <= pop_any;
    end
    always_comb rd_valid = rv_q;

    // R7
    empty_read_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && lvl_a[rd_port] == '0) |=> !rd_valid);

    // R2
    valid_cause_chk: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(rd_en));

    // R9
    one_hot_push_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(push_v) && $onehot0(pop_v));
endmodule

// File: tb/mq_shared_buf_tb.sv
`timescale 1ns/1ps
module mq_shared_buf_tb;
    localparam int NP = 4, AW = 6, DW = 16, CW = AW + 1, PW = 2;

    logic clk = 0, rst = 1;
    logic [NP*AW-1:0] cfg_base;
    logic [NP*CW-1:0] cfg_size;
    logic [CW-1:0] cfg_burst, cfg_margin;
    logic wr_en = 0, rd_en = 0;
    logic [PW-1:0] wr_port = 0, rd_port = 0;
    logic [DW-1:0] wr_data = 0;
    logic rd_valid;
    logic [DW-1:0] rd_data;
    logic [NP-1:0] port_ready, port_ovr, cfg_err;
    logic [NP*CW-1:0] port_level;

    int total = 0, bad = 0;
    int msize [NP];
    int mbase [NP];
    int q [NP][$];
    bit movr [NP];
    bit exp_rv;
    int exp_rd;
    int need;

    always #2.5 clk = ~clk;

    mq_shared_buf #(.NPORT(NP), .AW(AW), .DW(DW)) u_dut (
        .clk(clk), .rst(rst), .cfg_base(cfg_base), .cfg_size(cfg_size),
        .cfg_burst(cfg_burst), .cfg_margin(cfg_margin),
        .wr_en(wr_en), .wr_port(wr_port), .wr_data(wr_data),
        .rd_en(rd_en), .rd_port(rd_port), .rd_valid(rd_valid), .rd_data(rd_data),
        .port_ready(port_ready), .port_level(port_level), .port_ovr(port_ovr),
        .cfg_err(cfg_err)
    );

    task automatic chk(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic apply_cfg();
        for (int p = 0; p < NP; p++) begin
            cfg_base[p*AW +: AW] = AW'(mbase[p]);
            cfg_size[p*CW +: CW] = CW'(msize[p]);
        end
    endtask

    task automatic compare_all();
        for (int p = 0; p < NP; p++) begin
            int lv = int'(port_level[p*CW +: CW]);
            bit er = (msize[p] == 0) || (msize[p] < 2 * int'(cfg_margin)) ||
                     (mbase[p] + msize[p] > 64);
            chk($sformatf("R5 level p%0d", p), lv, q[p].size());
            chk($sformatf("R4 ready p%0d", p), int'(port_ready[p]),
                int'((msize[p] - q[p].size()) >= need));
            chk($sformatf("R6 overrun p%0d", p), int'(port_ovr[p]), int'(movr[p]));
            chk($sformatf("R8 cfg_err p%0d", p), int'(cfg_err[p]), int'(er));
        end
        chk("R7 rd_valid", int'(rd_valid), int'(exp_rv));
        if (exp_rv) chk("R2 rd_data", int'(rd_data), exp_rd);
    endtask

    // One clock: drive at falling edge, step the model, compare after the rise.
    task automatic cyc(bit we, int wp, int wd, bit re, int rp);
        bit pok, wok;
        wr_en = we; wr_port = PW'(wp); wr_data = DW'(wd);
        rd_en = re; rd_port = PW'(rp);
        pok = re && (q[rp].size() > 0);
        wok = we && (q[wp].size() < msize[wp]);
        if (we && !wok) movr[wp] = 1;
        exp_rv = pok;
        if (pok) exp_rd = q[rp].pop_front();
        if (wok) q[wp].push_back(wd & 16'hFFFF);
        @(posedge clk);
        @(negedge clk);
        compare_all();
    endtask

    task automatic do_reset();
        wr_en = 0; rd_en = 0; rst = 1;
        @(posedge clk); @(posedge clk); @(negedge clk);
        for (int p = 0; p < NP; p++) begin q[p].delete(); movr[p] = 0; end
        exp_rv = 0;
        // R1: cleared state while reset is held
        compare_all();
        rst = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog act=timeout exp=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        mbase = '{0, 12, 32, 40};
        msize = '{12, 20, 8, 24};
        cfg_burst = 2; cfg_margin = 3;
        need = 5;
        apply_cfg();
        do_reset();

        // R6 / R4: fill port 2 to its size, then push two more
        for (int i = 0; i < 10; i++) cyc(1, 2, 16'h200 + i, 0, 0);

        // R7: read from empty port 0
        cyc(0, 0, 0, 1, 0);

        // R2: drain two from port 2 in order
        cyc(0, 0, 0, 1, 2);
        cyc(0, 0, 0, 1, 2);

        // R5: same-port write and read together on port 2 and port 1
        cyc(1, 1, 16'h111, 0, 0);
        cyc(1, 1, 16'h112, 1, 1);
        cyc(1, 2, 16'h2AA, 1, 2);

        // R3 / R9: wrap port 2 many times while port 3 and port 1 move
        for (int i = 0; i < 40; i++) begin
            cyc(1, 2, 16'h2C00 + i, 1, 2);
            cyc(1, 3, 16'h3C00 + i, 1, (i % 3 == 0) ? 3 : 1);
        end

        // R8: invalid region settings on idle port 0
        msize[0] = 5; apply_cfg(); cyc(0, 0, 0, 0, 0);
        msize[0] = 0; apply_cfg(); cyc(0, 0, 0, 0, 0);
        mbase[0] = 60; msize[0] = 12; apply_cfg(); cyc(0, 0, 0, 0, 0);
        mbase[0] = 0; msize[0] = 12; apply_cfg(); cyc(0, 0, 0, 0, 0);

        // Mixed traffic on all ports
        for (int i = 0; i < 3000; i++) begin
            int r = $urandom;
            cyc(r[0], r[2:1], r[31:16], r[3] | r[4], r[6:5]);
        end

        // R1: reset clears overrun flags and levels mid-run
        do_reset();
        for (int i = 0; i < 6; i++) cyc(1, 0, 16'h0A0 + i, 0, 0);
        for (int i = 0; i < 7; i++) cyc(0, 0, 0, 1, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule